// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test holds. A request carries a 6-bit predicate and the current 32-bit floating-point status word. The block reads four condition flags from that word: negative, zero, infinity and not-a-number. It evaluates the predicate against them and answers one clock later. The answer is a true/false result, a flag for predicates outside the legal range, and the status word to write back.

The predicate has three fields. Bit 5 set makes the predicate illegal. Bit 4 selects the non-IEEE-aware group; when it is clear the test is IEEE-aware. Bits 3:0 give a 4-bit code. Codes 8 to 15 are the negations of codes 7 to 0: the code is XORed with 0xF and the base result is inverted.

Non-aware tests raise an unordered-branch exception in the returned status whenever the not-a-number flag is set. Aware tests never raise it. Target computation, loop counters and traps belong to the surrounding sequencer.

Top module: `fpc_branch_eval`

## Requirements
- R1: A predicate with bit 5 set (values 0x20 to 0x3F) is illegal. In the cycle after the request, `rsp_illegal` is 1 and `rsp_true` is 0.
- R2: For an illegal predicate, `stat_out` after the request equals the `stat_in` of that request, bit for bit.
- R3: Every cycle with `req_valid` high is followed by exactly one cycle of `rsp_valid` high carrying its answer. A cycle without a request gives `rsp_valid` 0, `rsp_true` 0 and `rsp_illegal` 0 in the next cycle, and leaves `stat_out` unchanged.
- R4: The status flag positions are fixed: negative is bit 27, zero is bit 26, infinity is bit 25 and not-a-number is bit 24. For legal codes 0 to 7 the result is as follows:
  - 0: always false.
  - 1: zero set.
  - 2: negative, zero and not-a-number all clear.
  - 3: zero set, or both negative and not-a-number clear.
  - 4: negative set while zero and not-a-number are clear.
  - 5: zero set, or negative set with not-a-number clear.
  - 6: both zero and not-a-number clear.
  - 7: not-a-number clear.
- R5: A legal code c from 8 to 15 gives the inverse of the result of code 15-c.
- R6: Predicate bit 4 does not change the true/false result. Bits 3:0 are evaluated the same way in both groups.
- R7: A legal non-aware predicate (bit 4 set) with not-a-number set sets bit 15 of `stat_out`, the unordered-branch exception. A legal aware predicate leaves bit 15 at 0.
- R8: For a legal predicate, the exception byte (bits 15:8) of `stat_out` is cleared apart from R7's bit 15. All other bits are copied from `stat_in`.
- R9: After reset, `rsp_valid`, `rsp_true` and `rsp_illegal` are 0 and `stat_out` is 0.
- R10: The infinity flag (bit 25) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe for this cycle |
| pred | input | 6 | Condition predicate |
| stat_in | input | 32 | Current floating-point status word |
| rsp_valid | output | 1 | One-cycle pulse with the answer |
| rsp_true | output | 1 | Predicate result |
| rsp_illegal | output | 1 | Predicate outside the legal range |
| stat_out | output | 32 | Status word to write back, held between requests |

## Verification
A wrong entry in the base truth table, a missing negation, or a swapped group decode changes `rsp_true` in the cycle after the request. Every predicate is applied against every flag combination, so such an error shows at the first request that reaches the faulty code. A wrong exception-byte mask or unordered-bit decision shows in `stat_out` in that same cycle. Because `stat_out` holds between requests, a stray write appears on the next idle cycle as a changed value.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int PRED_W = 6;
  localparam int CODE_W = 4;
  localparam int BASE_N = 8;

  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } fpc_flags_t;

  typedef struct packed {
    logic       illegal;
    logic       nonaware;
    logic       invert;
    logic [2:0] base;
  } fpc_dec_t;

  function automatic fpc_dec_t fpc_decode(input logic [PRED_W-1:0] p);
    fpc_dec_t   d;
    logic [CODE_W-1:0] code;
    code       = p[CODE_W-1:0];
    d.illegal  = p[PRED_W-1];
    d.nonaware = p[CODE_W];
    d.invert   = code[CODE_W-1];
    code       = d.invert ? (code ^ 4'hF) : code;
    d.base     = code[2:0];
    return d;
  endfunction

  function automatic logic fpc_base_hit(input logic [2:0] code, input fpc_flags_t f);
    logic r;
    case (code)
      3'd0:    r = 1'b0;
      3'd1:    r = f.zero;
      3'd2:    r = !(f.nan | f.zero | f.neg);
      3'd3:    r = f.zero | !(f.nan | f.neg);
      3'd4:    r = f.neg & !f.zero & !f.nan;
      3'd5:    r = f.zero | (f.neg & !f.nan);
      3'd6:    r = !(f.nan | f.zero);
      default: r = !f.nan;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpc_pred_decode.sv
module fpc_pred_decode
  import fpc_pkg::*;
(
  input  logic [PRED_W-1:0] pred,
  output fpc_dec_t          dec
);
  assign dec = fpc_decode(pred);
endmodule

// File: rtl/fpc_cond_eval.sv
module fpc_cond_eval
  import fpc_pkg::*;
(
  input  fpc_dec_t   dec,
  input  fpc_flags_t flags,
  output logic       result,
  output logic       unord_evt
);
  logic [BASE_N-1:0] hit_vec;

  for (genvar i = 0; i < BASE_N; i++) begin : g_base
    assign hit_vec[i] = fpc_base_hit(3'(i), flags);
  end

  logic raw_hit;
  assign raw_hit   = hit_vec[dec.base];
  assign result    = !dec.illegal & (raw_hit ^ dec.invert);
  assign unord_evt = !dec.illegal & dec.nonaware & flags.nan;
endmodule

// File: rtl/fpc_stat_update.sv
module fpc_stat_update #(
  parameter int STAT_W    = 32,
  parameter int EXC_LSB   = 8,
  parameter int EXC_W     = 8,
  parameter int UNORD_OFS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              illegal,
  input  logic              result,
  input  logic              unord_evt,
  output logic              rsp_valid,
  output logic              rsp_true,
  output logic              rsp_illegal,
  output logic [STAT_W-1:0] stat_out
);
  localparam logic [STAT_W-1:0] EXC_MASK =
    {{(STAT_W-EXC_W){1'b0}}, {EXC_W{1'b1}}} << EXC_LSB;
  localparam int UNORD_BIT = EXC_LSB + UNORD_OFS;

  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_in;
    if (!illegal) begin
      stat_nxt            = stat_in & ~EXC_MASK;
      stat_nxt[UNORD_BIT] = unord_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_true    <= 1'b0;
      rsp_illegal <= 1'b0;
      stat_out    <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_true    <= req_valid & result;
      rsp_illegal <= req_valid & illegal;
      if (req_valid) stat_out <= stat_nxt;
    end
  end

  a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_true && !rsp_illegal && $stable(stat_out)));
  a_r2_illegal_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && illegal) |=> stat_out == $past(stat_in));
  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !illegal) |=> (stat_out & ~EXC_MASK) == ($past(stat_in) & ~EXC_MASK));
endmodule

// File: rtl/fpc_branch_eval.sv
module fpc_branch_eval
  import fpc_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int CC_LSB    = 24,
  parameter int EXC_LSB   = 8,
  parameter int EXC_W     = 8,
  parameter int UNORD_OFS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [5:0]        pred,
  input  logic [STAT_W-1:0] stat_in,
  output logic              rsp_valid,
  output logic              rsp_true,
  output logic              rsp_illegal,
  output logic [STAT_W-1:0] stat_out
);
  localparam int UNORD_BIT = EXC_LSB + UNORD_OFS;

  fpc_flags_t flags;
  fpc_dec_t   dec;
  logic       cond_result;
  logic       cond_unord;

  assign flags = fpc_flags_t'(stat_in[CC_LSB +: 4]);

  fpc_pred_decode u_dec (
    .pred (pred),
    .dec  (dec)
  );

  fpc_cond_eval u_eval (
    .dec       (dec),
    .flags     (flags),
    .result    (cond_result),
    .unord_evt (cond_unord)
  );

  fpc_stat_update #(
    .STAT_W    (STAT_W),
    .EXC_LSB   (EXC_LSB),
    .EXC_W     (EXC_W),
    .UNORD_OFS (UNORD_OFS)
  ) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .stat_in     (stat_in),
    .illegal     (dec.illegal),
    .result      (cond_result),
    .unord_evt   (cond_unord),
    .rsp_valid   (rsp_valid),
    .rsp_true    (rsp_true),
    .rsp_illegal (rsp_illegal),
    .stat_out    (stat_out)
  );

  a_r1_illegal_false: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pred[5]) |=> (rsp_illegal && !rsp_true));
  a_r7_aware_no_unord: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pred[5] && !pred[4]) |=> !stat_out[UNORD_BIT]);
  a_r7_nonaware_unord: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pred[5] && pred[4] && stat_in[CC_LSB]) |=> stat_out[UNORD_BIT]);
  a_r4_false_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pred[3:0] == 4'h0) |=> !rsp_true);
endmodule

// File: tb/tb_fpc_branch_eval.sv
`timescale 1ns/1ps
module tb_fpc_branch_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  pred = '0;
  logic [31:0] stat_in = '0;
  logic        rsp_valid, rsp_true, rsp_illegal;
  logic [31:0] stat_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpc_branch_eval dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred(pred),
    .stat_in(stat_in), .rsp_valid(rsp_valid), .rsp_true(rsp_true),
    .rsp_illegal(rsp_illegal), .stat_out(stat_out)
  );

  // expected outputs for the cycle after the last drive
  bit          e_valid = 0, e_true = 0, e_ill = 0;
  logic [31:0] e_stat = '0;
  string       t_res = "R9", t_stat = "R9";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model: relations built from flags, then the 16-entry table
  function automatic bit model_truth(int code, bit n, bit z, bit nan);
    bit eqf = z;
    bit gtf = !nan && !z && !n;
    bit ltf = n && !nan && !z;
    bit t[8];
    t[0] = 0;       t[1] = eqf;       t[2] = gtf;       t[3] = eqf || gtf;
    t[4] = ltf;     t[5] = eqf || ltf; t[6] = gtf || ltf; t[7] = !nan;
    if (code >= 8) return !t[15 - code];
    return t[code];
  endfunction

  task automatic compare_all();
    check(t_res, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    check(t_res, "rsp_true", 32'(rsp_true), 32'(e_true));
    check(t_res, "rsp_illegal", 32'(rsp_illegal), 32'(e_ill));
    check(t_stat, "stat_out", stat_out, e_stat);
  endtask

  task automatic drive(bit v, int p, logic [31:0] s);
    req_valid = v;
    pred      = 6'(p);
    stat_in   = s;
    e_valid   = v;
    if (!v) begin
      e_true = 0; e_ill = 0;
      t_res = "R3"; t_stat = "R3";
    end else begin
      bit ill = (p >= 32);
      bit na  = p[4];
      int code = p & 15;
      e_ill  = ill;
      e_true = ill ? 0 : model_truth(code, s[27], s[26], s[24]);
      if (ill) t_res = "R1";
      else if (s[25]) t_res = "R10";
      else if (na) t_res = "R6";
      else if (code >= 8) t_res = "R5";
      else t_res = "R4";
      if (ill) begin
        e_stat = s; t_stat = "R2";
      end else begin
        e_stat = s;
        e_stat[15:8] = 8'h00;
        e_stat[15] = na && s[24];
        t_stat = (na && s[24]) ? "R7" : "R8";
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "rsp_valid", 32'(rsp_valid), 0);
    check("R9", "stat_out", stat_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "rsp_true", 32'(rsp_true), 0);
    check("R9", "rsp_illegal", 32'(rsp_illegal), 0);
    for (int p = 0; p < 64; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] s = $urandom;
        s[27:24] = 4'(f);
        if (f[0]) s[15:8] = 8'hFF;
        drive(1'b1, p, s);
        @(negedge clk);
        compare_all();
        if (((p * 16 + f) % 5) == 0) begin
          drive(1'b0, $urandom_range(0, 63), $urandom);
          @(negedge clk);
          compare_all();
        end
      end
    end
    // back-to-back requests alternating legal and illegal
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, (k % 2) ? 6'h3F : 6'h17, 32'h0100_FF00 | 32'(k));
      @(negedge clk);
      compare_all();
    end
    drive(1'b0, 0, '0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule